// File: doc/BRIEF.md
# Dual-Channel PIO Slot Access Sequencer

This block turns a stream of serial-bus time-slot events into bit-level accesses on two general-purpose I/O channels, A and B. Each event is a one-clock slot-start strobe with a slot type: read, write-0 or write-1. A separate one-clock strobe marks the moment the bus line has gone back to idle. For a read slot the block samples the synchronized pin level and hands back, within that same slot, the bit to drive onto the bus. For a write slot it schedules an update of the channel's output register.

Four configuration inputs set how accesses are spread over the channels:

- A channel-select field picks A only, B only, or both.
- An interleave bit chooses, in two-channel mode, between alternating accesses and paired accesses. Paired reads sample both pins at once; paired writes update both outputs together.
- An initial-mode bit gives the direction of the first byte.
- A toggle bit makes the direction flip after every completed byte.

Each channel also has an activity latch. It records the first edge seen on its pin, and one shared clear input empties both latches. A bus reset event restarts the byte and channel sequence and reloads the direction.

Top module: `pio_slot_seq`

## Requirements
- R1: While `rst_n` is low, `pio_out`, `act_latch`, `rd_bit` and `rd_valid` are 0 and `dir_read` is 1.
- R2: A clock with `bus_reset` high loads the direction from `cfg_im` (1 = read, 0 = write). It also restarts the sequence at channel A and access 0 of the byte, and forgets a held paired A write bit.
- R3: A byte is 8 accesses in every channel mode. With `cfg_tog`=0 the direction never changes. With `cfg_tog`=1 it inverts on the clock that takes the 8th access of a byte.
- R4: A slot whose type does not match the current direction, a slot of type 2'b11, and any slot while `cfg_chan`=2'b00 are ignored. Such a slot moves no output, no counter and no channel pointer. Slot type encoding: 2'b00 read, 2'b01 write-0, 2'b10 write-1.
- R5: With one channel selected (`cfg_chan` 2'b01 = A, 2'b10 = B), a read slot raises `rd_valid` for one clock after the slot-start clock. It sets `rd_bit` to the level the selected pin had three clocks before that clock (two-flop synchronizer). A write slot touches only the selected output.
- R6: With both channels selected and `cfg_interleave`=0, successive read slots sample A, B, A, B and so on, one pin per slot.
- R7: With both channels and `cfg_interleave`=1, a read slot on the A phase samples both pins and returns A. The following B-phase slot returns the stored B level without sampling.
- R8: With both channels and `cfg_interleave`=0, write slots update only A, then only B, alternately, so the two outputs never change on the same clock.
- R9: With both channels and `cfg_interleave`=1, the A-phase write bit is held. The B-phase slot then updates both outputs together, using the B slot's timing.
- R10: A write-1 access changes its output exactly `WR1_CYC` clocks after the slot-start clock. `WR1_CYC` is CLK_MHZ*WR1_NS/1000, which is 7500 at the defaults.
- R11: A write-0 access changes its output on the clock after `line_idle` is sampled high.
- R12: A channel's activity latch sets one clock after an edge appears on its synchronized pin and stays set. `act_clr` clears both latches on the next clock and wins over a simultaneous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | Bus reset event strobe |
| slot_start | input | 1 | Time-slot start strobe |
| slot_type | input | 2 | Type of the starting slot |
| line_idle | input | 1 | Line returned to idle strobe |
| cfg_chan | input | 2 | Channel select: bit 0 = A, bit 1 = B |
| cfg_interleave | input | 1 | 0 alternating, 1 paired two-channel access |
| cfg_tog | input | 1 | Flip direction after each byte |
| cfg_im | input | 1 | Initial direction, 1 = read |
| act_clr | input | 1 | Clear both activity latches |
| pio_in | input | 2 | Pin levels, bit 0 = A, bit 1 = B |
| pio_out | output | 2 | Output registers, bit 0 = A, bit 1 = B |
| rd_bit | output | 1 | Bit to return in the current read slot |
| rd_valid | output | 1 | One-clock pulse when rd_bit is new |
| act_latch | output | 2 | Activity latches, bit 0 = A, bit 1 = B |
| dir_read | output | 1 | Current direction, 1 = read |

## Verification
The assertions assume three things about the inputs. No slot starts while a write is still waiting for its delay or for the idle strobe. The configuration does not change in the middle of a byte. Interleave stays constant while the single-change property on the outputs is watched. The stimulus respects all three. Every write slot is followed by an idle strobe and a gap longer than the write-1 delay. Configuration is changed only between slots and is always followed by a bus reset, so every byte starts at channel A with a known direction.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;

    typedef enum logic [1:0] {
        SLOT_RD   = 2'b00,
        SLOT_W0   = 2'b01,
        SLOT_W1   = 2'b10,
        SLOT_NONE = 2'b11
    } slot_e;

    typedef struct packed {
        logic       valid;
        logic [1:0] mask;
        logic [1:0] val;
        logic       on_idle;
    } wr_req_t;

endpackage

// File: rtl/pio_pin_in.sv
module pio_pin_in #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic act_clr,
    output logic pin_s,
    output logic act
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sh;
        logic                   prev;
        logic                   act;
    } pin_st_t;

    pin_st_t st_q, st_d;
    logic    edge_seen;

    always_comb begin
        st_d      = st_q;
        pin_s     = st_q.sh[SYNC_STAGES-1];
        edge_seen = st_q.sh[SYNC_STAGES-1] ^ st_q.prev;
        st_d.sh   = {st_q.sh[SYNC_STAGES-2:0], pin};
        st_d.prev = st_q.sh[SYNC_STAGES-1];
        if (act_clr) begin
            st_d.act = 1'b0;
        end else if (edge_seen) begin
            st_d.act = 1'b1;
        end
        act = st_q.act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_ACT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        act_clr |=> !act); // R12
    AST_ACT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !act_clr) |=> act); // R12

endmodule

// File: rtl/pio_seq_ctrl.sv
module pio_seq_ctrl
    import pio_seq_pkg::*;
#(
    parameter int BYTE_ACC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_reset,
    input  logic       slot_start,
    input  logic [1:0] slot_type,
    input  logic [1:0] cfg_chan,
    input  logic       cfg_interleave,
    input  logic       cfg_tog,
    input  logic       cfg_im,
    input  logic [1:0] pin_s,
    output logic       rd_bit,
    output logic       rd_valid,
    output logic       dir_read,
    output wr_req_t    wr_req
);

    localparam int CW = (BYTE_ACC > 1) ? $clog2(BYTE_ACC) : 1;

    typedef struct packed {
        logic          dir;
        logic [CW-1:0] cnt;
        logic          ch;
        logic          hold_a;
        logic          hold_b;
        logic          rd_bit;
        logic          rd_valid;
    } ctrl_st_t;

    ctrl_st_t st_q, st_d;
    logic     match, both, sel, paired, wbit, is_wr;

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = 1'b0;
        wr_req        = '0;
        is_wr         = (slot_type == SLOT_W0) || (slot_type == SLOT_W1);
        wbit          = (slot_type == SLOT_W1);
        both          = (cfg_chan == 2'b11);
        sel           = both ? st_q.ch : cfg_chan[1];
        paired        = both && cfg_interleave;
        match         = slot_start && (cfg_chan != 2'b00) &&
                        ((st_q.dir && slot_type == SLOT_RD) || (!st_q.dir && is_wr));
        if (bus_reset) begin
            st_d.dir    = cfg_im;
            st_d.cnt    = '0;
            st_d.ch     = 1'b0;
            st_d.hold_a = 1'b0;
        end else if (match) begin
            if (st_q.dir) begin
                st_d.rd_valid = 1'b1;
                if (paired && !st_q.ch) begin
                    st_d.rd_bit = pin_s[0];
                    st_d.hold_b = pin_s[1];
                end else if (paired) begin
                    st_d.rd_bit = st_q.hold_b;
                end else begin
                    st_d.rd_bit = pin_s[sel];
                end
            end else begin
                if (paired && !st_q.ch) begin
                    st_d.hold_a = wbit;
                end else begin
                    wr_req.valid   = 1'b1;
                    wr_req.on_idle = !wbit;
                    if (paired) begin
                        wr_req.mask = 2'b11;
                        wr_req.val  = {wbit, st_q.hold_a};
                    end else begin
                        wr_req.mask = sel ? 2'b10 : 2'b01;
                        wr_req.val  = {wbit, wbit};
                    end
                end
            end
            if (both) begin
                st_d.ch = ~st_q.ch;
            end
            if (st_q.cnt == CW'(BYTE_ACC - 1)) begin
                st_d.cnt = '0;
                if (cfg_tog) begin
                    st_d.dir = ~st_q.dir;
                end
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
        rd_bit   = st_q.rd_bit;
        rd_valid = st_q.rd_valid;
        dir_read = st_q.dir;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.dir <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    AST_BUS_RESET_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (st_q.cnt == '0 && !st_q.ch && dir_read == $past(cfg_im))); // R2
    AST_BYTE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !bus_reset && cfg_tog && st_q.cnt == CW'(BYTE_ACC - 1))
        |=> (dir_read != $past(dir_read))); // R3
    AST_NO_TOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_reset && !cfg_tog) |=> $stable(dir_read)); // R3
    AST_RDV_FROM_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(slot_start)); // R5

endmodule

// File: rtl/pio_wr_apply.sv
module pio_wr_apply
    import pio_seq_pkg::*;
#(
    parameter int WR1_CYC = 7500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slot_start,
    input  logic       line_idle,
    input  wr_req_t    req,
    output logic [1:0] pio_out
);

    localparam int TW = $clog2(WR1_CYC + 1);

    typedef struct packed {
        logic          pend;
        logic [1:0]    mask;
        logic [1:0]    val;
        logic          on_idle;
        logic [TW-1:0] tmr;
        logic [1:0]    out;
    } wr_st_t;

    wr_st_t st_q, st_d;
    logic   apply;

    always_comb begin
        st_d  = st_q;
        apply = 1'b0;
        if (st_q.pend) begin
            if (st_q.on_idle) begin
                apply = line_idle;
            end else if (st_q.tmr == TW'(1)) begin
                apply = 1'b1;
            end else begin
                st_d.tmr = st_q.tmr - TW'(1);
            end
        end
        if (apply) begin
            st_d.out  = (st_q.out & ~st_q.mask) | (st_q.val & st_q.mask);
            st_d.pend = 1'b0;
        end
        if (req.valid) begin
            st_d.pend    = 1'b1;
            st_d.mask    = req.mask;
            st_d.val     = req.val;
            st_d.on_idle = req.on_idle;
            st_d.tmr     = TW'(WR1_CYC);
        end
        pio_out = st_q.out;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_NO_SLOT_WHILE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |-> !slot_start); // R10
    AST_W0_WAITS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && st_q.on_idle && !line_idle) |=> $stable(pio_out)); // R11
    AST_W1_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !st_q.on_idle && st_q.tmr != TW'(1)) |=> $stable(pio_out)); // R10

endmodule

// File: rtl/pio_slot_seq.sv
module pio_slot_seq
    import pio_seq_pkg::*;
#(
    parameter int CLK_MHZ     = 200,
    parameter int WR1_NS      = 37500,
    parameter int BYTE_ACC    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_reset,
    input  logic       slot_start,
    input  logic [1:0] slot_type,
    input  logic       line_idle,
    input  logic [1:0] cfg_chan,
    input  logic       cfg_interleave,
    input  logic       cfg_tog,
    input  logic       cfg_im,
    input  logic       act_clr,
    input  logic [1:0] pio_in,
    output logic [1:0] pio_out,
    output logic       rd_bit,
    output logic       rd_valid,
    output logic [1:0] act_latch,
    output logic       dir_read
);

    localparam int WR1_CYC = (CLK_MHZ * WR1_NS) / 1000;
    localparam int NCH     = 2;

    logic [NCH-1:0] pin_s;
    wr_req_t        wr_req;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        pio_pin_in #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin     (pio_in[g]),
            .act_clr (act_clr),
            .pin_s   (pin_s[g]),
            .act     (act_latch[g])
        );
    end

    pio_seq_ctrl #(.BYTE_ACC(BYTE_ACC)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_reset      (bus_reset),
        .slot_start     (slot_start),
        .slot_type      (slot_type),
        .cfg_chan       (cfg_chan),
        .cfg_interleave (cfg_interleave),
        .cfg_tog        (cfg_tog),
        .cfg_im         (cfg_im),
        .pin_s          (pin_s),
        .rd_bit         (rd_bit),
        .rd_valid       (rd_valid),
        .dir_read       (dir_read),
        .wr_req         (wr_req)
    );

    pio_wr_apply #(.WR1_CYC(WR1_CYC)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_start (slot_start),
        .line_idle  (line_idle),
        .req        (wr_req),
        .pio_out    (pio_out)
    );

    AST_ASYNC_ONE_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_interleave && !$past(cfg_interleave))
        |-> ($countones(pio_out ^ $past(pio_out)) <= 1)); // R8

endmodule

// File: tb/pio_slot_seq_bench.sv
`timescale 1ns/1ps
module pio_slot_seq_bench;

    localparam int CLK_MHZ = 200;
    localparam int WR1_NS  = 100;
    localparam int WR1     = CLK_MHZ * WR1_NS / 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_reset = 1'b0, slot_start = 1'b0, line_idle = 1'b0;
    logic [1:0] slot_type = 2'b11;
    logic [1:0] cfg_chan = 2'b01;
    logic       cfg_interleave = 1'b0, cfg_tog = 1'b0, cfg_im = 1'b1;
    logic       act_clr = 1'b0;
    logic [1:0] pio_in = 2'b00;
    logic [1:0] pio_out, act_latch;
    logic       rd_bit, rd_valid, dir_read;

    int    total = 0;
    int    bad = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    pio_slot_seq #(.CLK_MHZ(CLK_MHZ), .WR1_NS(WR1_NS)) u_pio_slot_seq (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .slot_start(slot_start),
        .slot_type(slot_type), .line_idle(line_idle), .cfg_chan(cfg_chan),
        .cfg_interleave(cfg_interleave), .cfg_tog(cfg_tog), .cfg_im(cfg_im),
        .act_clr(act_clr), .pio_in(pio_in), .pio_out(pio_out), .rd_bit(rd_bit),
        .rd_valid(rd_valid), .act_latch(act_latch), .dir_read(dir_read)
    );

    // behavioural reference model
    logic [1:0] m_p1, m_p2, m_p3, m_act, m_out, m_mask, m_val;
    logic       m_rd, m_rdv, m_dir, m_ch, m_ha, m_hb, m_pend, m_idle;
    int         m_cnt, m_tmr;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_p1 = 0; m_p2 = 0; m_p3 = 0; m_act = 0; m_out = 0; m_rd = 0; m_rdv = 0;
            m_dir = 1; m_cnt = 0; m_ch = 0; m_ha = 0; m_hb = 0; m_pend = 0;
            m_mask = 0; m_val = 0; m_idle = 0; m_tmr = 0;
        end else begin
            bit both, c, w1, hit;
            m_rdv = 0;
            if (act_clr) m_act = 0;
            else m_act = m_act | (m_p2 ^ m_p3);
            if (m_pend) begin
                if (m_idle ? line_idle : (m_tmr == 1)) begin
                    m_out = (m_out & ~m_mask) | (m_val & m_mask);
                    m_pend = 0;
                end else if (!m_idle) m_tmr--;
            end
            hit = slot_start && cfg_chan != 0 &&
                  (m_dir ? slot_type == 2'b00 : (slot_type == 2'b01 || slot_type == 2'b10));
            if (bus_reset) begin
                m_dir = cfg_im; m_cnt = 0; m_ch = 0; m_ha = 0;
            end else if (hit) begin
                both = (cfg_chan == 2'b11);
                c    = both ? m_ch : (cfg_chan == 2'b10);
                w1   = (slot_type == 2'b10);
                if (m_dir) begin
                    m_rdv = 1;
                    if (both && cfg_interleave) begin
                        if (!m_ch) begin m_rd = m_p2[0]; m_hb = m_p2[1]; end
                        else m_rd = m_hb;
                    end else m_rd = m_p2[c];
                end else if (both && cfg_interleave && !m_ch) begin
                    m_ha = w1;
                end else begin
                    m_pend = 1; m_idle = !w1; m_tmr = WR1;
                    if (both && cfg_interleave) begin m_mask = 2'b11; m_val = {w1, m_ha}; end
                    else begin m_mask = c ? 2'b10 : 2'b01; m_val = {w1, w1}; end
                end
                if (both) m_ch = !m_ch;
                m_cnt++;
                if (m_cnt == 8) begin m_cnt = 0; if (cfg_tog) m_dir = !m_dir; end
            end
            m_p3 = m_p2; m_p2 = m_p1; m_p1 = pio_in;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            total++;
            if (pio_out !== m_out || rd_bit !== m_rd || rd_valid !== m_rdv ||
                act_latch !== m_act || dir_read !== m_dir) begin
                bad++;
                $display("FAIL %s out=%b/%b rd=%b/%b rdv=%b/%b act=%b/%b dir=%b/%b (actual/expected)",
                         cur_req, pio_out, m_out, rd_bit, m_rd, rd_valid, m_rdv,
                         act_latch, m_act, dir_read, m_dir);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic slot(input logic [1:0] t);
        @(negedge clk); slot_start = 1; slot_type = t;
        @(negedge clk); slot_start = 0; slot_type = 2'b11;
        if (t == 2'b00 || t == 2'b11) tick(3);
        else begin
            tick(4);
            if (t == 2'b01) begin line_idle = 1; tick(1); line_idle = 0; end
            tick(WR1 + 3);
        end
    endtask

    task automatic setup(input logic [1:0] ch, input logic il, input logic tg, input logic im);
        @(negedge clk);
        cfg_chan = ch; cfg_interleave = il; cfg_tog = tg; cfg_im = im; bus_reset = 1;
        @(negedge clk); bus_reset = 0;
    endtask

    initial begin
        // R1: reset state
        tick(3);
        total++;
        if (pio_out !== 0 || act_latch !== 0 || rd_bit !== 0 || rd_valid !== 0 || dir_read !== 1) begin
            bad++;
            $display("FAIL R1 out=%b act=%b rd=%b rdv=%b dir=%b expected 00 00 0 0 1",
                     pio_out, act_latch, rd_bit, rd_valid, dir_read);
        end
        @(negedge clk); rst_n = 1;
        tick(2);

        cur_req = "R5"; // single channel A reads, pins varying
        setup(2'b01, 0, 0, 1);
        for (int i = 0; i < 10; i++) begin
            pio_in = 2'(i * 3 + 1);
            slot(2'b00);
        end
        cur_req = "R4"; // mismatched and null slots ignored
        slot(2'b10); slot(2'b01); slot(2'b11);
        @(negedge clk); cfg_chan = 2'b00; slot(2'b00);

        cur_req = "R10"; // channel B writes, write-1 delay and write-0 idle
        setup(2'b10, 0, 0, 0);
        slot(2'b10); slot(2'b01); slot(2'b10); slot(2'b00);
        cur_req = "R11";
        slot(2'b01); slot(2'b10); slot(2'b01);

        cur_req = "R6"; // both channels alternating reads then writes
        setup(2'b11, 0, 1, 1);
        for (int i = 0; i < 8; i++) begin
            pio_in = 2'(i ^ (i >> 1));
            slot(2'b00);
        end
        cur_req = "R8";
        for (int i = 0; i < 8; i++) slot((i % 3 == 0) ? 2'b01 : 2'b10);
        cur_req = "R3";
        slot(2'b00); slot(2'b10);

        cur_req = "R9"; // paired writes then paired reads
        setup(2'b11, 1, 1, 0);
        slot(2'b10); slot(2'b10); slot(2'b01); slot(2'b10);
        slot(2'b10); slot(2'b01); slot(2'b01); slot(2'b01);
        cur_req = "R7";
        for (int i = 0; i < 8; i++) begin
            pio_in = 2'(i + 1);
            slot(2'b00);
        end

        cur_req = "R2"; // bus reset mid-byte
        setup(2'b11, 0, 1, 1);
        slot(2'b00); slot(2'b00); slot(2'b00);
        setup(2'b11, 0, 1, 0);
        slot(2'b10); slot(2'b01);

        cur_req = "R12"; // activity latches
        @(negedge clk); act_clr = 1; @(negedge clk); act_clr = 0;
        tick(4);
        pio_in = pio_in ^ 2'b01; tick(6);
        pio_in = pio_in ^ 2'b10; tick(2);
        act_clr = 1; tick(2); act_clr = 0; tick(6);
        pio_in = pio_in ^ 2'b11; tick(6);

        tick(4);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog %s expired", cur_req);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule